// File: doc/BRIEF.md
# DMA Byte/Word Handshake Sequencer

This block connects a host DMA channel, which always moves 16-bit words, to a parallel peripheral that is served one handshake at a time. In word mode each DMA word is one handshake on all sixteen data lines. In byte mode the sequencer splits each word into two handshakes on the low eight lines. The low byte goes first and the upper output lines are held at zero. For input it starts peripheral handshakes by itself, builds the word and only then requests the DMA cycle. For output it requests the word first and then plays it out to the peripheral.

The host end is a level request `dreq` that is answered by a one-cycle acknowledge `dack`. The host may raise a terminal-count pulse `dma_tc` together with that acknowledge. The terminal count is held in an internal flag until software clears it with `tc_clr`. While the flag is set, no new word is started. Each peripheral handshake is started with a one-cycle `hs_start` to the handshake controller, and that controller returns a one-cycle `hs_done` when the handshake ends. Input data is taken at `hs_done`.

Top module: `dma_bw_seq`

## Requirements
- R1: With `word_mode`=1, each DMA word uses exactly one handshake. `per_dout` carries the full 16-bit word taken at the acknowledge, and `host_rdata` returns the full `per_din` sampled at `hs_done`.
- R2: With `word_mode`=0, each DMA word uses exactly two handshakes. The first handshake carries bits 7:0 and the second carries bits 15:8. On input, `per_din[7:0]` of the first handshake becomes `host_rdata[7:0]` and that of the second becomes `host_rdata[15:8]`. `per_din[15:8]` is ignored.
- R3: With `word_mode`=0, `per_dout[15:8]` is zero for every output handshake.
- R4: For input, `dreq` rises only after all handshakes of the word have completed. `host_rdata` holds the finished word while `dreq` is high.
- R5: For output, `dreq` rises before any handshake of the word. The first handshake begins after the acknowledge.
- R6: With input enabled and no terminal count latched, the block keeps starting input words without software action. `tc_flag` sets on `dma_tc` together with an accepted acknowledge and clears on `tc_clr`. When both arrive in the same cycle, the set takes priority.
- R7: If `tc_clr` is pulsed while input stays enabled, one more word is started. That word uses one extra handshake in word mode or two in byte mode, and then `dreq` is raised again.
- R8: After an acknowledge that comes with `dma_tc`, no new request and no new word follow. On output, the handshakes of that last word still complete.
- R9: When both `in_en` and `out_en` are low, the block returns to idle at the next handshake boundary. A pending `dreq` drops one cycle later.
- R10: `dma_active` is high whenever a request or a handshake is pending, and low in idle.
- R11: `dma_tc` without an acknowledge does not change `tc_flag`.
- R12: After reset, `dreq`, `hs_start`, `dma_active` and `tc_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_en | input | 1 | DMA input enable (takes precedence) |
| out_en | input | 1 | DMA output enable |
| word_mode | input | 1 | 1: one 16-bit handshake per word; 0: two byte handshakes |
| tc_clr | input | 1 | Clears the terminal-count flag |
| dreq | output | 1 | DMA request to host |
| dack | input | 1 | DMA acknowledge, one cycle |
| dma_tc | input | 1 | Terminal count from host, valid with dack |
| host_wdata | input | DATA_W | Output word from host, taken on dack |
| host_rdata | output | DATA_W | Assembled input word for host |
| tc_flag | output | 1 | Latched terminal count |
| dma_active | output | 1 | Sequencer busy with a word |
| hs_start | output | 1 | Start one peripheral handshake |
| hs_done | input | 1 | Peripheral handshake finished |
| per_dout | output | DATA_W | Data lines to peripheral |
| per_din | input | DATA_W | Data lines from peripheral |

## Verification
The bench builds the block with the default `DATA_W` of 16, so both byte lanes and the zeroed upper lane can be observed. It sweeps both directions and both widths with transfers of one to four words. The handshake latency and the acknowledge latency are varied between runs. The expected handshake counts, byte order, data values and request timing are computed arithmetically from the handshake index. Separate runs cover a terminal-count clear while input is still enabled, enables dropped in the middle of a word, and a stray terminal-count pulse.

// File: rtl/dma_bw_pkg.sv
package dma_bw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OREQ = 3'd1,
    ST_GO   = 3'd2,
    ST_WAIT = 3'd3,
    ST_IREQ = 3'd4
  } seq_state_e;

  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } seq_dir_e;
endpackage

// File: rtl/dma_bw_tclatch.sv
module dma_bw_tclatch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R6
  tc_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_i));
endmodule

// File: rtl/dma_bw_ctrl.sv
module dma_bw_ctrl
  import dma_bw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_en,
  input  logic out_en,
  input  logic word_mode,
  input  logic tc_flag,
  input  logic dack,
  input  logic hs_done,
  output logic dreq,
  output logic hs_start,
  output logic active,
  output logic lane,
  output logic wmode,
  output logic load_word,
  output logic cap_in,
  output logic ack_take
);
  seq_state_e st_q, st_d;
  seq_dir_e   dir_q, dir_d;
  logic       lane_q, lane_d;
  logic       wm_q, wm_d;
  logic       any_en, last_hs;

  assign any_en  = in_en | out_en;
  assign last_hs = wm_q | lane_q;

  always_comb begin
    st_d   = st_q;
    dir_d  = dir_q;
    lane_d = lane_q;
    wm_d   = wm_q;
    case (st_q)
      ST_IDLE: begin
        if (!tc_flag && in_en) begin
          st_d = ST_GO;  dir_d = DIR_IN;  lane_d = 1'b0; wm_d = word_mode;
        end else if (!tc_flag && out_en) begin
          st_d = ST_OREQ; dir_d = DIR_OUT; lane_d = 1'b0; wm_d = word_mode;
        end
      end
      ST_OREQ: begin
        if (!any_en)   st_d = ST_IDLE;
        else if (dack) begin st_d = ST_GO; lane_d = 1'b0; end
      end
      ST_GO: st_d = ST_WAIT;
      ST_WAIT: begin
        if (hs_done) begin
          if (!any_en)              st_d = ST_IDLE;
          else if (!last_hs)        begin st_d = ST_GO; lane_d = 1'b1; end
          else if (dir_q == DIR_IN) st_d = ST_IREQ;
          else                      st_d = ST_IDLE;
        end
      end
      ST_IREQ: begin
        if (!any_en || dack) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dir_q  <= DIR_IN;
      lane_q <= 1'b0;
      wm_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      dir_q  <= dir_d;
      lane_q <= lane_d;
      wm_q   <= wm_d;
    end
  end

  assign dreq      = (st_q == ST_OREQ) || (st_q == ST_IREQ);
  assign hs_start  = (st_q == ST_GO);
  assign active    = (st_q != ST_IDLE);
  assign lane      = lane_q;
  assign wmode     = wm_q;
  assign load_word = (st_q == ST_OREQ) && dack;
  assign cap_in    = (st_q == ST_WAIT) && hs_done && (dir_q == DIR_IN);
  assign ack_take  = dreq && dack;

  // R4
  in_req_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dreq) && dir_q == DIR_IN) |-> $past(hs_done));

  // R9
  drop_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && !in_en && !out_en) |=> !dreq);

  // R2
  hs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_start |=> !hs_start);
endmodule

// File: rtl/dma_bw_lanes.sv
module dma_bw_lanes #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_word,
  input  logic              cap_in,
  input  logic              lane,
  input  logic              wmode,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] per_din,
  output logic [DATA_W-1:0] per_dout,
  output logic [DATA_W-1:0] host_rdata
);
  localparam int LANE_W = DATA_W / 2;
  localparam int NLANE  = 2;

  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] in_q, in_d;
  logic [LANE_W-1:0] out_byte;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic take;
    assign take = wmode || (lane == g[0]);
    assign in_d[g*LANE_W +: LANE_W] = !take ? in_q[g*LANE_W +: LANE_W] :
                                      (wmode ? per_din[g*LANE_W +: LANE_W]
                                             : per_din[LANE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_q <= '0;
    else if (load_word) out_q <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      in_q <= '0;
    else if (cap_in) in_q <= in_d;
  end

  assign out_byte   = lane ? out_q[DATA_W-1:LANE_W] : out_q[LANE_W-1:0];
  assign per_dout   = wmode ? out_q : {{(DATA_W-LANE_W){1'b0}}, out_byte};
  assign host_rdata = in_q;

  // R3
  byte_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wmode && !load_word) |=> (wmode || per_dout[DATA_W-1:LANE_W] == '0));
endmodule

// File: rtl/dma_bw_seq.sv
module dma_bw_seq #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_en,
  input  logic              out_en,
  input  logic              word_mode,
  input  logic              tc_clr,
  output logic              dreq,
  input  logic              dack,
  input  logic              dma_tc,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              tc_flag,
  output logic              dma_active,
  output logic              hs_start,
  input  logic              hs_done,
  output logic [DATA_W-1:0] per_dout,
  input  logic [DATA_W-1:0] per_din
);
  logic lane, wmode, load_word, cap_in, ack_take;

  dma_bw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .out_en(out_en),
    .word_mode(word_mode), .tc_flag(tc_flag), .dack(dack), .hs_done(hs_done),
    .dreq(dreq), .hs_start(hs_start), .active(dma_active), .lane(lane),
    .wmode(wmode), .load_word(load_word), .cap_in(cap_in), .ack_take(ack_take)
  );

  dma_bw_lanes #(.DATA_W(DATA_W)) u_lanes (
    .clk(clk), .rst_n(rst_n), .load_word(load_word), .cap_in(cap_in),
    .lane(lane), .wmode(wmode), .host_wdata(host_wdata), .per_din(per_din),
    .per_dout(per_dout), .host_rdata(host_rdata)
  );

  dma_bw_tclatch u_tc (
    .clk(clk), .rst_n(rst_n), .set_i(ack_take && dma_tc), .clr_i(tc_clr),
    .flag_o(tc_flag)
  );

  // R8
  tc_last_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && dack && dma_tc) |=> !dreq);

  // R10
  active_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq || hs_start) |-> dma_active);

  // R11
  tc_stray_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc_flag && !(dreq && dack)) |=> !tc_flag);
endmodule

// File: tb/tb_dma_bw_seq.sv
module tb_dma_bw_seq;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_en = 1'b0, out_en = 1'b0, word_mode = 1'b0, tc_clr = 1'b0;
  logic dack = 1'b0, dma_tc = 1'b0, hs_done = 1'b0;
  logic [DW-1:0] host_wdata = '0, per_din = '0;
  logic dreq, tc_flag, dma_active, hs_start;
  logic [DW-1:0] host_rdata, per_dout;

  always #10 clk = ~clk;

  dma_bw_seq #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .out_en(out_en),
    .word_mode(word_mode), .tc_clr(tc_clr), .dreq(dreq), .dack(dack),
    .dma_tc(dma_tc), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tc_flag(tc_flag), .dma_active(dma_active), .hs_start(hs_start),
    .hs_done(hs_done), .per_dout(per_dout), .per_din(per_din)
  );

  int checks = 0, fails = 0, cycles = 0;
  int hs_cnt = 0, pdelay = 1, hdelay = 0;
  int nwords = 0, ack_cnt = 0, act_bad = 0;
  logic host_on = 1'b0;
  logic [DW-1:0] out_log [0:63];
  logic [DW-1:0] rd_log [0:15];
  int req_hs [0:15];

  function automatic logic [DW-1:0] pin(int k);
    return 16'(16'hC35A + k * 16'h01F3);
  endfunction
  function automatic logic [DW-1:0] wpat(int j);
    return 16'(16'h81E7 + j * 16'h2B49);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // peripheral handshake model
  initial begin
    forever begin
      @(negedge clk);
      hs_done = 1'b0;
      if (hs_start) begin
        int idx;
        idx = hs_cnt;
        if (idx < 64) out_log[idx] = per_dout;
        hs_cnt++;
        repeat (pdelay) @(negedge clk);
        per_din = pin(idx);
        hs_done = 1'b1;
      end
    end
  end

  // host DMA model
  initial begin
    forever begin
      @(negedge clk);
      dack = 1'b0;
      dma_tc = 1'b0;
      if (dreq && !dma_active) act_bad++;
      if (dreq && host_on && ack_cnt < nwords) begin
        if (ack_cnt < 16) req_hs[ack_cnt] = hs_cnt;
        repeat (hdelay) @(negedge clk);
        if (dreq) begin
          if (ack_cnt < 16) rd_log[ack_cnt] = host_rdata;
          host_wdata = wpat(ack_cnt);
          dack = 1'b1;
          dma_tc = (ack_cnt + 1 == nwords);
          ack_cnt++;
        end
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  task automatic pulse_clr();
    @(negedge clk); tc_clr = 1'b1;
    @(negedge clk); tc_clr = 1'b0;
  endtask

  task automatic run(input logic wm, input logic dir_out, input int n, input int d, input int hd);
    int base, per, spins;
    per = wm ? 1 : 2;
    pdelay = d; hdelay = hd;
    nwords = n; ack_cnt = 0; act_bad = 0; host_on = 1'b1;
    base = hs_cnt;
    word_mode = wm;
    pulse_clr();
    if (dir_out) out_en = 1'b1; else in_en = 1'b1;
    spins = 0;
    do begin
      @(negedge clk); spins++;
    end while (!(tc_flag && !dma_active && ack_cnt == n) && spins < 3000);
    repeat (10) @(negedge clk);
    // R8: stop after last terminal count, enables still high
    chk(!dreq && hs_cnt - base == n * per, "R8 stop", 32'(hs_cnt - base), 32'(n * per));
    chk(tc_flag, "R6 tc latched", 32'(tc_flag), 1);
    if (wm) chk(hs_cnt - base == n, "R1 hs per word", 32'(hs_cnt - base), 32'(n));
    else    chk(hs_cnt - base == 2 * n, "R2 hs per word", 32'(hs_cnt - base), 32'(2 * n));
    chk(act_bad == 0, "R10 active with dreq", 32'(act_bad), 0);
    for (int j = 0; j < n; j++) begin
      if (!dir_out) begin
        logic [DW-1:0] e;
        e = wm ? pin(base + j) : {pin(base + 2*j + 1)[7:0], pin(base + 2*j)[7:0]};
        chk(req_hs[j] - base == (j + 1) * per, "R4 req after hs", 32'(req_hs[j] - base), 32'((j + 1) * per));
        chk(rd_log[j] == e, wm ? "R1 in word" : "R2 in bytes", 32'(rd_log[j]), 32'(e));
      end else begin
        chk(req_hs[j] - base == j * per, "R5 req before hs", 32'(req_hs[j] - base), 32'(j * per));
        if (wm) chk(out_log[base + j] == wpat(j), "R1 out word", 32'(out_log[base + j]), 32'(wpat(j)));
        else begin
          logic [DW-1:0] w;
          w = wpat(j);
          chk(out_log[base + 2*j] == {8'h00, w[7:0]}, "R3 R2 out low", 32'(out_log[base + 2*j]), 32'({8'h00, w[7:0]}));
          chk(out_log[base + 2*j + 1] == {8'h00, w[15:8]}, "R3 R2 out high", 32'(out_log[base + 2*j + 1]), 32'({8'h00, w[15:8]}));
        end
      end
    end
    in_en = 1'b0; out_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!dreq && !hs_start && !dma_active && !tc_flag, "R12 reset",
        32'({dreq, hs_start, dma_active, tc_flag}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 stray terminal count
    dma_tc = 1'b1;
    @(negedge clk);
    dma_tc = 1'b0;
    @(negedge clk);
    chk(!tc_flag, "R11 stray tc", 32'(tc_flag), 0);

    for (int wm = 0; wm < 2; wm++)
      for (int dir = 0; dir < 2; dir++)
        for (int n = 1; n <= 4; n++)
          run(wm[0], dir[0], n, 1 + (n % 3), (n + dir) % 2);

    // R7 / R6 / R9: clear TC with input still enabled
    for (int wm = 0; wm < 2; wm++) begin
      int base, per, spins;
      per = wm ? 1 : 2;
      run(wm[0], 1'b0, 1, 1, 0);
      host_on = 1'b0;
      in_en = 1'b1;
      repeat (5) @(negedge clk);
      base = hs_cnt;
      pulse_clr();
      spins = 0;
      while (!dreq && spins < 200) begin @(negedge clk); spins++; end
      repeat (5) @(negedge clk);
      chk(dreq && hs_cnt - base == per, "R7 extra handshakes", 32'(hs_cnt - base), 32'(per));
      if (!wm) chk(host_rdata == {pin(base + 1)[7:0], pin(base)[7:0]}, "R7 R2 extra word",
                   32'(host_rdata), 32'({pin(base + 1)[7:0], pin(base)[7:0]}));
      in_en = 1'b0;
      @(negedge clk);
      chk(!dreq && !dma_active, "R9 request drop", 32'({dreq, dma_active}), 0);
    end

    // R9: enables dropped mid byte pair on output
    begin
      int base, spins;
      pdelay = 3; hdelay = 0; nwords = 8; ack_cnt = 0; host_on = 1'b1;
      word_mode = 1'b0;
      pulse_clr();
      base = hs_cnt;
      out_en = 1'b1;
      spins = 0;
      while (hs_cnt == base && spins < 200) begin @(negedge clk); spins++; end
      out_en = 1'b0;
      repeat (20) @(negedge clk);
      chk(hs_cnt - base == 1 && !dma_active && !dreq, "R9 boundary stop", 32'(hs_cnt - base), 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule